// File: doc/BRIEF.md
# Banked Register File with Indirect Access

This block holds the data memory of a small 8-bit core. The instruction supplies a 7-bit file field. The block combines that field with bank-select bits held in its own STATUS register to form an effective byte address. When the field is zero, the access goes through a pointer register instead. In that case the effective 9-bit address is the indirect-bank bit of STATUS followed by the 8-bit pointer. Only this indirect form can reach the upper banks.

A handful of core special registers decode at the same offset in every bank, so software reaches them without switching banks. These are the program-counter low byte, STATUS, the pointer, the program-counter high latch and the interrupt-control byte. General-purpose bytes sit above the special-register area. Bank 0 has a larger window than the other banks.

Reads are combinational from the presented file field. A write strobe commits the write data at the next rising clock edge. The current bank-select bits are brought out for the rest of the core.

Top module: `banked_regfile`

## Requirements
- R1: After reset, STATUS reads 0x18 (both active-low flags high) and bank_bits is 0. The pointer, PCL, the high latch and the interrupt-control byte each read 0x00.
- R2: In direct mode (file field not 0), the effective address is {0, STATUS bit 5, field}. STATUS bit 6 has no effect with the default of two banks.
- R3: A file field of 0x00 accesses effective address {STATUS bit 7, pointer[7:0]}. An effective bank index of 2 or more is unimplemented.
- R4: An indirect access whose pointer selects offset 0x00 of any bank reads 0x00. A write through it changes nothing.
- R5: PCL (offset 0x02), STATUS (0x03), the pointer (0x04), the high latch (0x0A) and interrupt-control (0x0B) are each one register, reached at that offset in every bank.
- R6: General-purpose storage spans offsets 0x20–0x7F in bank 0 and 0x20–0x3F in bank 1. Each bank's bytes are separate storage.
- R7: Unimplemented locations read 0x00 and ignore writes. These are offsets 0x01, 0x05–0x09 and 0x0C–0x1F, bank-1 offsets 0x40–0x7F, and absent banks.
- R8: STATUS layout: bit 7 is the indirect bank, bits 6:5 are the direct bank, bit 4 is the time-out flag (active low), bit 3 is the power-down flag (active low), and bits 2/1/0 are zero, digit carry and carry. Bits 4 and 3 ignore writes; all other bits take the written value.
- R9: The high latch holds 5 bits, and its bits 7:5 read as 0.
- R10: bank_bits equals STATUS[7:5] and follows a STATUS write from the next cycle.
- R11: rd_data reflects the current file field and stored state in the same cycle. A write is visible from the cycle after its strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| file_addr | input | 7 | File field from the instruction |
| wr_en | input | 1 | Write strobe, committed at the clock edge |
| wr_data | input | 8 | Byte to store |
| rd_data | output | 8 | Byte at the resolved address |
| bank_bits | output | 3 | STATUS[7:5]: indirect bank, direct bank high, direct bank low |

## Verification
The properties assume that wr_en and file_addr are held steady across each rising edge and are never unknown once reset is released. The bench changes them only on the falling edge, so this always holds. They also assume that general-purpose bytes are written before they are read; a bench prefill pass writes every implemented byte first. Random STATUS and pointer writes are allowed, so the indirect bank and direct bank bits wander freely. This drives accesses into absent banks and into the pointer-to-itself case as often as into real storage.

// File: rtl/brf_pkg.sv
package brf_pkg;

    typedef enum logic [2:0] {
        RG_NONE,
        RG_PCL,
        RG_STATUS,
        RG_FSR,
        RG_PCLATH,
        RG_INTCON,
        RG_GPR
    } region_e;

    // Offsets within a bank; shared decode with the core sequencer
    localparam logic [6:0] OFF_INDF   = 7'h00;
    localparam logic [6:0] OFF_PCL    = 7'h02;
    localparam logic [6:0] OFF_STATUS = 7'h03;
    localparam logic [6:0] OFF_FSR    = 7'h04;
    localparam logic [6:0] OFF_PCLATH = 7'h0A;
    localparam logic [6:0] OFF_INTCON = 7'h0B;

    localparam logic [7:0] STATUS_RST   = 8'h18;
    localparam logic [7:0] STATUS_WMASK = 8'hE7;
    localparam int         PCLATH_W     = 5;

endpackage

// File: rtl/brf_addr_resolve.sv
module brf_addr_resolve
    import brf_pkg::*;
#(
    parameter int         NUM_BANKS = 2,
    parameter logic [6:0] GPR_BASE  = 7'h20,
    parameter logic [6:0] GPR0_LAST = 7'h7F,
    parameter logic [6:0] GPRN_LAST = 7'h3F
) (
    input  logic [6:0] file_addr,
    input  logic       irp,
    input  logic [1:0] rp,
    input  logic [7:0] fsr,
    output region_e    region,
    output logic [1:0] bank,
    output logic [6:0] off
);
    localparam int BANK_BITS = (NUM_BANKS > 2) ? 2 : 1;

    logic [8:0] ea;
    logic [6:0] gpr_last;

    always_comb begin
        if (file_addr == OFF_INDF) begin
            ea = {irp, fsr};
        end else begin
            ea = {2'b00, file_addr};
            ea[7 +: BANK_BITS] = rp[BANK_BITS-1:0];
        end
    end

    assign bank     = ea[8:7];
    assign off      = ea[6:0];
    assign gpr_last = (bank == 2'd0) ? GPR0_LAST : GPRN_LAST;

    always_comb begin
        region = RG_NONE;
        if (int'(bank) < NUM_BANKS) begin
            unique case (off)
                OFF_PCL:    region = RG_PCL;
                OFF_STATUS: region = RG_STATUS;
                OFF_FSR:    region = RG_FSR;
                OFF_PCLATH: region = RG_PCLATH;
                OFF_INTCON: region = RG_INTCON;
                default: begin
                    if (off >= GPR_BASE && off <= gpr_last)
                        region = RG_GPR;
                end
            endcase
        end
    end
endmodule

// File: rtl/brf_core_sfr.sv
module brf_core_sfr
    import brf_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  region_e             region,
    input  logic [7:0]          wdata,
    output logic [7:0]          status_q,
    output logic [7:0]          fsr_q,
    output logic [7:0]          pcl_q,
    output logic [7:0]          intcon_q,
    output logic [PCLATH_W-1:0] pclath_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= STATUS_RST;
            fsr_q    <= '0;
            pcl_q    <= '0;
            intcon_q <= '0;
            pclath_q <= '0;
        end else if (wr_en) begin
            unique case (region)
                RG_STATUS: status_q <= (wdata & STATUS_WMASK) | (status_q & ~STATUS_WMASK);
                RG_FSR:    fsr_q    <= wdata;
                RG_PCL:    pcl_q    <= wdata;
                RG_INTCON: intcon_q <= wdata;
                RG_PCLATH: pclath_q <= wdata[PCLATH_W-1:0];
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/brf_gpr_banks.sv
module brf_gpr_banks #(
    parameter int         NUM_BANKS = 2,
    parameter logic [6:0] GPR_BASE  = 7'h20,
    parameter logic [6:0] GPR0_LAST = 7'h7F,
    parameter logic [6:0] GPRN_LAST = 7'h3F
) (
    input  logic       clk,
    input  logic       wr_en,
    input  logic [1:0] bank,
    input  logic [6:0] off,
    input  logic [7:0] wdata,
    output logic [7:0] rdata
);
    logic [6:0] idx;
    logic [7:0] bank_rd [NUM_BANKS];

    assign idx = off - GPR_BASE;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        localparam int DEPTH = int'(((b == 0) ? GPR0_LAST : GPRN_LAST) - GPR_BASE) + 1;
        localparam int AW    = $clog2(DEPTH);

        logic [7:0] mem [DEPTH];
        logic       hit;

        assign hit = (int'(idx) < DEPTH);

        always_ff @(posedge clk) begin
            if (wr_en && bank == 2'(b) && hit)
                mem[idx[AW-1:0]] <= wdata;
        end

        assign bank_rd[b] = hit ? mem[idx[AW-1:0]] : 8'h00;
    end

    always_comb begin
        rdata = 8'h00;
        for (int b = 0; b < NUM_BANKS; b++)
            if (bank == 2'(b))
                rdata = bank_rd[b];
    end
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
    import brf_pkg::*;
#(
    parameter int         NUM_BANKS = 2,
    parameter logic [6:0] GPR_BASE  = 7'h20,
    parameter logic [6:0] GPR0_LAST = 7'h7F,
    parameter logic [6:0] GPRN_LAST = 7'h3F
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [6:0] file_addr,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    output logic [2:0] bank_bits
);
    region_e             region;
    logic [1:0]          bank;
    logic [6:0]          off;
    logic [7:0]          status_q;
    logic [7:0]          fsr_q;
    logic [7:0]          pcl_q;
    logic [7:0]          intcon_q;
    logic [PCLATH_W-1:0] pclath_q;
    logic [7:0]          gpr_rd;

    brf_addr_resolve #(
        .NUM_BANKS(NUM_BANKS), .GPR_BASE(GPR_BASE),
        .GPR0_LAST(GPR0_LAST), .GPRN_LAST(GPRN_LAST)
    ) u_resolve (
        .file_addr(file_addr),
        .irp      (status_q[7]),
        .rp       (status_q[6:5]),
        .fsr      (fsr_q),
        .region   (region),
        .bank     (bank),
        .off      (off)
    );

    brf_core_sfr u_sfr (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .region  (region),
        .wdata   (wr_data),
        .status_q(status_q),
        .fsr_q   (fsr_q),
        .pcl_q   (pcl_q),
        .intcon_q(intcon_q),
        .pclath_q(pclath_q)
    );

    brf_gpr_banks #(
        .NUM_BANKS(NUM_BANKS), .GPR_BASE(GPR_BASE),
        .GPR0_LAST(GPR0_LAST), .GPRN_LAST(GPRN_LAST)
    ) u_gpr (
        .clk  (clk),
        .wr_en(wr_en && region == RG_GPR),
        .bank (bank),
        .off  (off),
        .wdata(wr_data),
        .rdata(gpr_rd)
    );

    always_comb begin
        unique case (region)
            RG_PCL:    rd_data = pcl_q;
            RG_STATUS: rd_data = status_q;
            RG_FSR:    rd_data = fsr_q;
            RG_PCLATH: rd_data = 8'(pclath_q);
            RG_INTCON: rd_data = intcon_q;
            RG_GPR:    rd_data = gpr_rd;
            default:   rd_data = 8'h00;
        endcase
    end

    assign bank_bits = status_q[7:5];
endmodule

// File: rtl/brf_checker.sv
module brf_checker
    import brf_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic [6:0] file_addr,
    input logic       wr_en,
    input logic [2:0] wr_bank,
    input logic [7:0] rd_data,
    input logic [2:0] bank_bits,
    input region_e    region,
    input logic [1:0] status_flags,
    input logic [7:0] fsr_q
);
    a_r10_bank_follow: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && region == RG_STATUS) |=> (bank_bits == $past(wr_bank)));

    a_r8_flags_ro: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && region == RG_STATUS) |=> $stable(status_flags));

    a_r4_indf_self: assert property (@(posedge clk) disable iff (!rst_n)
        (file_addr == 7'h00 && (fsr_q & 8'h7F) == 8'h00) |-> (rd_data == 8'h00));

    a_r7_none_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (region == RG_NONE) |-> (rd_data == 8'h00));

    a_r9_latch_high: assert property (@(posedge clk) disable iff (!rst_n)
        (file_addr == 7'h0A) |-> (rd_data[7:5] == 3'b000));
endmodule

bind banked_regfile brf_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .file_addr   (file_addr),
    .wr_en       (wr_en),
    .wr_bank     (wr_data[7:5]),
    .rd_data     (rd_data),
    .bank_bits   (bank_bits),
    .region      (region),
    .status_flags(status_q[4:3]),
    .fsr_q       (fsr_q)
);

// File: tb/sim_banked_regfile.sv
`timescale 1ns/1ps
module sim_banked_regfile;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [6:0] file_addr;
    logic       wr_en;
    logic [7:0] wr_data;
    logic [7:0] rd_data;
    logic [2:0] bank_bits;

    int checks   = 0;
    int failures = 0;

    banked_regfile u0 (
        .clk(clk), .rst_n(rst_n), .file_addr(file_addr), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .bank_bits(bank_bits)
    );

    always #10 clk = ~clk;

    // reference state built from the requirements
    logic [7:0] m_status, m_fsr, m_pcl, m_intcon, m_pclath;
    logic [7:0] m_gpr [512];

    function automatic logic [8:0] m_ea(logic [6:0] f);
        if (f == 7'h00) return {m_status[7], m_fsr};
        return {1'b0, m_status[5], f};
    endfunction

    // 0 none, 1 pcl, 2 status, 3 fsr, 4 latch, 5 intcon, 6 gpr
    function automatic int m_kind(logic [8:0] ea);
        logic [6:0] o = ea[6:0];
        if (ea[8]) return 0;
        if (o == 7'h02) return 1;
        if (o == 7'h03) return 2;
        if (o == 7'h04) return 3;
        if (o == 7'h0A) return 4;
        if (o == 7'h0B) return 5;
        if (o >= 7'h20 && (!ea[7] || o <= 7'h3F)) return 6;
        return 0;
    endfunction

    function automatic logic [7:0] m_read(logic [6:0] f);
        logic [8:0] ea = m_ea(f);
        case (m_kind(ea))
            1: return m_pcl;
            2: return m_status;
            3: return m_fsr;
            4: return m_pclath;
            5: return m_intcon;
            6: return m_gpr[ea];
            default: return 8'h00;
        endcase
    endfunction

    task automatic m_write(logic [6:0] f, logic [7:0] d);
        logic [8:0] ea = m_ea(f);
        case (m_kind(ea))
            1: m_pcl    = d;
            2: m_status = (d & 8'hE7) | (m_status & 8'h18);
            3: m_fsr    = d;
            4: m_pclath = d & 8'h1F;
            5: m_intcon = d;
            6: m_gpr[ea] = d;
            default: ;
        endcase
    endtask

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=0x%02h expected=0x%02h", tag, act, exp);
        end
    endtask

    // want < 0: compare against the reference only
    task automatic step(logic [6:0] f, bit we, logic [7:0] d, string tag, int want);
        @(negedge clk);
        file_addr = f;
        wr_en     = we;
        wr_data   = d;
        #2;
        check({tag, " rd"}, int'(rd_data), int'(m_read(f)));
        check("R10 bank_bits", int'(bank_bits), int'(m_status[7:5]));
        if (want >= 0) check({tag, " explicit"}, int'(rd_data), want);
        if (we) m_write(f, d);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog R11 actual=hung expected=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        rst_n = 1'b0; file_addr = '0; wr_en = 1'b0; wr_data = '0;
        m_status = 8'h18; m_fsr = 0; m_pcl = 0; m_intcon = 0; m_pclath = 0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        step(7'h03, 0, 0, "R1 status", 8'h18);
        step(7'h04, 0, 0, "R1 fsr", 8'h00);
        step(7'h02, 0, 0, "R1 pcl", 8'h00);
        step(7'h0A, 0, 0, "R1 latch", 8'h00);
        step(7'h0B, 0, 0, "R1 intcon", 8'h00);

        // R8 flags ignore writes
        step(7'h03, 1, 8'h00, "R8 clear", -1);
        step(7'h03, 0, 0, "R8 flags kept", 8'h18);
        step(7'h03, 1, 8'h07, "R8 low bits", -1);
        step(7'h03, 0, 0, "R8 zdc c", 8'h1F);

        // prefill all general-purpose bytes (R6)
        step(7'h03, 1, 8'h00, "R6 bank0", -1);
        for (int o = 'h20; o <= 'h7F; o++) step(7'(o), 1, 8'(o) ^ 8'h5A, "R6 fill0", -1);
        step(7'h03, 1, 8'h20, "R6 bank1", -1);
        for (int o = 'h20; o <= 'h3F; o++) step(7'(o), 1, 8'(o) ^ 8'hC3, "R6 fill1", -1);

        // R2 / R6 banks are separate, RP1 ignored
        step(7'h25, 1, 8'hA5, "R6 wr bank1", -1);
        step(7'h03, 1, 8'h00, "R2 sel0", -1);
        step(7'h25, 1, 8'h11, "R6 wr bank0", -1);
        step(7'h25, 0, 0, "R6 rd bank0", 8'h11);
        step(7'h03, 1, 8'h40, "R2 rp1 only", -1);
        step(7'h25, 0, 0, "R2 rp1 ignored", 8'h11);
        step(7'h03, 1, 8'h60, "R2 rp1 rp0", -1);
        step(7'h25, 0, 0, "R2 bank1", 8'hA5);

        // R5 mirrors
        step(7'h04, 1, 8'h3C, "R5 fsr bank1", -1);
        step(7'h0B, 1, 8'h81, "R5 intcon bank1", -1);
        step(7'h03, 1, 8'h00, "R5 sel0", -1);
        step(7'h04, 0, 0, "R5 fsr bank0", 8'h3C);
        step(7'h0B, 0, 0, "R5 intcon bank0", 8'h81);

        // R9 latch width
        step(7'h0A, 1, 8'hFF, "R9 wr", -1);
        step(7'h0A, 0, 0, "R9 rd", 8'h1F);

        // R3 indirect
        step(7'h04, 1, 8'hA5, "R3 ptr", -1);
        step(7'h00, 0, 0, "R3 via ptr bank1", 8'hA5);
        step(7'h04, 1, 8'h25, "R3 ptr", -1);
        step(7'h00, 1, 8'h77, "R3 wr via ptr", -1);
        step(7'h25, 0, 0, "R3 direct sees", 8'h77);
        step(7'h04, 1, 8'h83, "R3 ptr status", -1);
        step(7'h00, 0, 0, "R3 status via ptr", 8'h18);
        step(7'h03, 1, 8'h80, "R3 irp", -1);
        step(7'h04, 1, 8'h25, "R3 ptr", -1);
        step(7'h00, 1, 8'h55, "R3 absent bank", 8'h00);
        step(7'h03, 1, 8'h00, "R3 irp0", -1);
        step(7'h25, 0, 0, "R3 untouched", 8'h77);

        // R4 pointer to itself
        step(7'h04, 1, 8'h00, "R4 ptr0", -1);
        step(7'h00, 1, 8'h99, "R4 self", 8'h00);
        step(7'h04, 0, 0, "R4 ptr kept", 8'h00);
        step(7'h04, 1, 8'h80, "R4 ptr80", -1);
        step(7'h00, 1, 8'h66, "R4 self b1", 8'h00);
        step(7'h04, 0, 0, "R4 ptr kept b1", 8'h80);

        // R7 unimplemented
        step(7'h03, 1, 8'h20, "R7 bank1", -1);
        step(7'h50, 1, 8'h33, "R7 hole", 8'h00);
        step(7'h50, 0, 0, "R7 hole rd", 8'h00);
        step(7'h07, 1, 8'h44, "R7 slot", 8'h00);
        step(7'h01, 0, 0, "R7 slot01", 8'h00);
        step(7'h03, 1, 8'h00, "R7 bank0", -1);
        step(7'h50, 0, 0, "R7 bank0 kept", 8'h50 ^ 8'h5A);

        // R11 random traffic
        for (int i = 0; i < 3000; i++) begin
            int r = int'($urandom % 100);
            logic [6:0] f;
            if (r < 20)      f = 7'h00;
            else if (r < 28) f = 7'h03;
            else if (r < 36) f = 7'h04;
            else             f = 7'($urandom);
            step(f, bit'($urandom % 2), 8'($urandom), "R11 random", -1);
        end

        @(negedge clk) wr_en = 1'b0;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule